// File: doc/BRIEF.md
# Floating-Point ADC Input Crossbar with Exponent Scaling

This block sits at the input of a multichannel digital downconverter. It takes four sample ports. Each port carries a 16-bit two's-complement mantissa and a 3-bit exponent from a gain-ranging converter. The block normalises every mantissa by its exponent, so larger exponent codes give 6 dB more attenuation per step.

Ports 0/1 can be fused into one complex I/Q input, and so can ports 2/3. Each fusion is enabled on its own. A per-channel crossbar hands each processing channel either a real sample or a fused I/Q pair.

A single parallel configuration word holds all the settings:

| Bits | Meaning |
|---|---|
| [4k+2:4k] | Port select for channel k (channels 0..5) |
| 4k+3 | Complex-request bit for channel k |
| 24 | Pairs ports 0/1 |
| 25 | Pairs ports 2/3 |

The block also registers a per-port gain-exponent output with a drive enable. When a pair is fused, only the exponent of its I-side port is driven.

Top module: `adc_xbar_scaler`

## Requirements
- R1: While reset is asserted (rst_n low), every output is zero, regardless of the inputs.
- R2: The scaled value of a port is its signed mantissa divided by 2^e, rounded toward minus infinity (arithmetic right shift with sign extension), for every exponent code e from 0 to 7.
- R3: out_valid_o equals in_valid_i delayed by exactly one clock. Channel data captured with a valid sample appears on the cycle after that sample.
- R4: When in_valid_i is low, the channel outputs ch_i_o, ch_q_o and ch_err_o keep their previous values.
- R5: A channel whose complex bit is 0 and whose select is 0..3 outputs the scaled selected port on I, zero on Q, and error 0.
- R6: A channel whose complex bit is 1 and whose select is 0 (with cfg bit 24 set) or 2 (with cfg bit 25 set) outputs the scaled select port on I, the scaled next port on Q, and error 0.
- R7: A channel whose complex bit is 1 but whose select is 1 or 3, or whose pair bit is clear, outputs the scaled selected port on I, zero on Q, and error 1.
- R8: A select code of 4..7 gives zero on I and Q and error 0, whatever the complex bit.
- R9: Each cycle, gain_exp_o slot p (bits [3p+2:3p]) takes that port's exponent and gain_exp_en_o[p] goes to 1. The exceptions are port 1 while bit 24 is set and port 3 while bit 25 is set: their slots go to 0 and their enables to 0.
- R10: The two pair bits act independently. Pairing ports 2/3 alone leaves ports 0/1 real, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input sample strobe |
| port_data_i | input | 64 | Four mantissas, port p at [16p+15:16p] |
| port_exp_i | input | 12 | Four exponents, port p at [3p+2:3p] |
| cfg_i | input | 26 | Channel fields and pair bits |
| out_valid_o | output | 1 | Output strobe |
| ch_i_o | output | 96 | I sample for each of six channels |
| ch_q_o | output | 96 | Q sample for each of six channels |
| ch_err_o | output | 6 | Per-channel complex misuse flag |
| gain_exp_o | output | 12 | Gain-control exponent for each port |
| gain_exp_en_o | output | 4 | Drive enable for each exponent slot |

## Verification
Each fault shows at the ports one clock after the inputs that expose it. A bad shift or a missing sign extension shows up as a wrong I value on the first valid sample that uses the faulty exponent code. A crossbar or pairing fault shows as a misrouted I or Q, or as a wrong error flag, on the first sample of that configuration. A broken hold path shows as changed data during the first idle cycle. The bench drives sweeps of every exponent code, all real routings, each misuse case and idle stretches. It then runs random traffic and compares every output against a behavioural model on every clock.

// File: rtl/adc_xbar_pkg.sv
package adc_xbar_pkg;
    localparam int PORTS      = 4;
    localparam int SEL_W      = 3;
    localparam int CH_FIELD_W = SEL_W + 1;
    localparam int MAX_CH     = 6;
    localparam int PAIR01_BIT = 24;
    localparam int PAIR23_BIT = 25;
    localparam int CFG_W      = PAIR23_BIT + 1;
endpackage

// File: rtl/adc_port_scaler.sv
module adc_port_scaler #(
    parameter int SAMPLE_W = 16,
    parameter int EXP_W    = 3
) (
    input  logic [SAMPLE_W-1:0] mant_i,
    input  logic [EXP_W-1:0]    exp_i,
    output logic [SAMPLE_W-1:0] scaled_o
);
    // Arithmetic shift keeps the sign of negative mantissas
    always_comb begin
        scaled_o = SAMPLE_W'($signed(mant_i) >>> exp_i);
    end
endmodule

// File: rtl/adc_chan_router.sv
module adc_chan_router
    import adc_xbar_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] scaled_i [PORTS],
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                cplx_i,
    input  logic [1:0]          pair_en_i,
    output logic [SAMPLE_W-1:0] i_o,
    output logic [SAMPLE_W-1:0] q_o,
    output logic                err_o
);
    always_comb begin
        i_o   = '0;
        q_o   = '0;
        err_o = 1'b0;
        if (!sel_i[SEL_W-1]) begin
            i_o = scaled_i[sel_i[1:0]];
            if (cplx_i) begin
                if (!sel_i[0] && pair_en_i[sel_i[1]]) begin
                    q_o = scaled_i[{sel_i[1], 1'b1}];
                end else begin
                    err_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_xbar_scaler.sv
module adc_xbar_scaler
    import adc_xbar_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int EXP_W    = 3,
    parameter int NUM_CH   = MAX_CH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid_i,
    input  logic [PORTS*SAMPLE_W-1:0]  port_data_i,
    input  logic [PORTS*EXP_W-1:0]     port_exp_i,
    input  logic [CFG_W-1:0]           cfg_i,
    output logic                       out_valid_o,
    output logic [NUM_CH*SAMPLE_W-1:0] ch_i_o,
    output logic [NUM_CH*SAMPLE_W-1:0] ch_q_o,
    output logic [NUM_CH-1:0]          ch_err_o,
    output logic [PORTS*EXP_W-1:0]     gain_exp_o,
    output logic [PORTS-1:0]           gain_exp_en_o
);
    localparam int PAIRS = PORTS / 2;

    typedef struct packed {
        logic                           valid;
        logic [NUM_CH-1:0][SAMPLE_W-1:0] i;
        logic [NUM_CH-1:0][SAMPLE_W-1:0] q;
        logic [NUM_CH-1:0]              err;
        logic [PORTS-1:0][EXP_W-1:0]    gexp;
        logic [PORTS-1:0]               gen;
    } state_t;

    state_t st_d, st_q;

    logic [SAMPLE_W-1:0] scaled [PORTS];
    logic [SAMPLE_W-1:0] rt_i   [NUM_CH];
    logic [SAMPLE_W-1:0] rt_q   [NUM_CH];
    logic [NUM_CH-1:0]   rt_err;
    logic [PAIRS-1:0]    pair_en;

    assign pair_en = {cfg_i[PAIR23_BIT], cfg_i[PAIR01_BIT]};

    for (genvar p = 0; p < PORTS; p++) begin : g_scale
        adc_port_scaler #(.SAMPLE_W(SAMPLE_W), .EXP_W(EXP_W)) i_scale (
            .mant_i  (port_data_i[p*SAMPLE_W +: SAMPLE_W]),
            .exp_i   (port_exp_i[p*EXP_W +: EXP_W]),
            .scaled_o(scaled[p])
        );
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_route
        adc_chan_router #(.SAMPLE_W(SAMPLE_W)) i_route (
            .scaled_i (scaled),
            .sel_i    (cfg_i[k*CH_FIELD_W +: SEL_W]),
            .cplx_i   (cfg_i[k*CH_FIELD_W + SEL_W]),
            .pair_en_i(pair_en),
            .i_o      (rt_i[k]),
            .q_o      (rt_q[k]),
            .err_o    (rt_err[k])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            for (int k = 0; k < NUM_CH; k++) begin
                st_d.i[k]   = rt_i[k];
                st_d.q[k]   = rt_q[k];
                st_d.err[k] = rt_err[k];
            end
        end
        for (int p = 0; p < PORTS; p++) begin
            if ((p % 2 == 1) && pair_en[p/2]) begin
                st_d.gexp[p] = '0;
                st_d.gen[p]  = 1'b0;
            end else begin
                st_d.gexp[p] = port_exp_i[p*EXP_W +: EXP_W];
                st_d.gen[p]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o   = st_q.valid;
    assign ch_i_o        = st_q.i;
    assign ch_q_o        = st_q.q;
    assign ch_err_o      = st_q.err;
    assign gain_exp_o    = st_q.gexp;
    assign gain_exp_en_o = st_q.gen;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(ch_i_o) && $stable(ch_q_o) && $stable(ch_err_o))); // R4
    AST_PAIR01_EXP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[PAIR01_BIT] |=> (!gain_exp_en_o[1] && gain_exp_o[EXP_W +: EXP_W] == '0)); // R9
    AST_PAIR23_EXP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[PAIR23_BIT] |=> (!gain_exp_en_o[3] && gain_exp_o[3*EXP_W +: EXP_W] == '0)); // R9

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        AST_ERR_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ch_err_o[k] |-> (ch_q_o[k*SAMPLE_W +: SAMPLE_W] == '0)); // R7
        AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && cfg_i[k*CH_FIELD_W + SEL_W - 1]) |=>
            (ch_i_o[k*SAMPLE_W +: SAMPLE_W] == '0 && ch_q_o[k*SAMPLE_W +: SAMPLE_W] == '0
             && !ch_err_o[k])); // R8
    end
endmodule

// File: tb/test_adc_xbar_scaler.sv
module test_adc_xbar_scaler;
    localparam int SW  = 16;
    localparam int EW  = 3;
    localparam int NCH = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              in_valid;
    logic [4*SW-1:0]   port_data;
    logic [4*EW-1:0]   port_exp;
    logic [25:0]       cfg;
    logic              out_valid_o;
    logic [NCH*SW-1:0] ch_i_o, ch_q_o;
    logic [NCH-1:0]    ch_err_o;
    logic [4*EW-1:0]   gain_exp_o;
    logic [3:0]        gain_exp_en_o;

    adc_xbar_scaler i_adc_xbar_scaler (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .port_data_i(port_data),
        .port_exp_i(port_exp), .cfg_i(cfg), .out_valid_o(out_valid_o),
        .ch_i_o(ch_i_o), .ch_q_o(ch_q_o), .ch_err_o(ch_err_o),
        .gain_exp_o(gain_exp_o), .gain_exp_en_o(gain_exp_en_o)
    );

    int checks = 0;
    int errors = 0;

    int          drv_d [4];
    int          drv_e [4];
    logic [25:0] drv_cfg;
    bit          drv_v;
    string       phase_tag = "";

    logic        m_valid;
    logic [15:0] m_i [NCH];
    logic [15:0] m_q [NCH];
    logic        m_err [NCH];
    logic [2:0]  m_gexp [4];
    logic        m_gen [4];
    string       m_tag [NCH];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic int ref_scale(int v, int e);
        int d = 1 << e;
        if (v >= 0) return v / d;
        return -((-v + d - 1) / d);
    endfunction

    function automatic logic [25:0] chf(int k, int sel, bit c);
        logic [25:0] f = '0;
        f[k*4 +: 3] = sel[2:0];
        f[k*4 + 3]  = c;
        return f;
    endfunction

    task automatic compare_all();
        chk("R3", "out_valid", 32'(out_valid_o), 32'(m_valid));
        for (int k = 0; k < NCH; k++) begin
            chk(m_tag[k], $sformatf("ch%0d I", k), 32'(ch_i_o[k*SW +: SW]), 32'(m_i[k]));
            chk(m_tag[k], $sformatf("ch%0d Q", k), 32'(ch_q_o[k*SW +: SW]), 32'(m_q[k]));
            chk(m_tag[k], $sformatf("ch%0d err", k), 32'(ch_err_o[k]), 32'(m_err[k]));
        end
        for (int p = 0; p < 4; p++) begin
            chk("R9", $sformatf("gain exp %0d", p), 32'(gain_exp_o[p*EW +: EW]), 32'(m_gexp[p]));
            chk("R9", $sformatf("gain en %0d", p), 32'(gain_exp_en_o[p]), 32'(m_gen[p]));
        end
    endtask

    task automatic apply_and_model();
        int s [4];
        in_valid = drv_v;
        cfg      = drv_cfg;
        for (int p = 0; p < 4; p++) begin
            port_data[p*SW +: SW] = SW'(drv_d[p]);
            port_exp[p*EW +: EW]  = EW'(drv_e[p]);
            s[p] = ref_scale(drv_d[p], drv_e[p]);
        end
        m_valid = drv_v;
        for (int k = 0; k < NCH; k++) begin
            int  sel = int'(drv_cfg[k*4 +: 3]);
            bit  c   = drv_cfg[k*4 + 3];
            if (!drv_v) begin
                m_tag[k] = "R4";
            end else begin
                if (sel > 3) begin
                    m_i[k] = '0; m_q[k] = '0; m_err[k] = 1'b0; m_tag[k] = "R8";
                end else if (!c) begin
                    m_i[k] = 16'(s[sel]); m_q[k] = '0; m_err[k] = 1'b0; m_tag[k] = "R5";
                end else if ((sel == 0 && drv_cfg[24]) || (sel == 2 && drv_cfg[25])) begin
                    m_i[k] = 16'(s[sel]); m_q[k] = 16'(s[sel+1]); m_err[k] = 1'b0; m_tag[k] = "R6";
                end else begin
                    m_i[k] = 16'(s[sel]); m_q[k] = '0; m_err[k] = 1'b1; m_tag[k] = "R7";
                end
                if (phase_tag != "") m_tag[k] = phase_tag;
            end
        end
        for (int p = 0; p < 4; p++) begin
            bit quiet = (p == 1 && drv_cfg[24]) || (p == 3 && drv_cfg[25]);
            m_gexp[p] = quiet ? 3'd0 : 3'(drv_e[p]);
            m_gen[p]  = !quiet;
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        apply_and_model();
    endtask

    task automatic rand_data();
        for (int p = 0; p < 4; p++) begin
            drv_d[p] = int'($urandom_range(0, 65535)) - 32768;
            drv_e[p] = int'($urandom_range(0, 7));
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b1;
        port_data = {4{16'h8123}};
        port_exp  = 12'hFFF;
        cfg       = 26'h3FFFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", 32'(out_valid_o), 0);
        chk("R1", "ch_i", 32'(|ch_i_o), 0);
        chk("R1", "ch_q", 32'(|ch_q_o), 0);
        chk("R1", "ch_err", 32'(ch_err_o), 0);
        chk("R1", "gain exp", 32'(gain_exp_o), 0);
        chk("R1", "gain en", 32'(gain_exp_en_o), 0);
        m_valid = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            m_i[k] = '0; m_q[k] = '0; m_err[k] = 1'b0; m_tag[k] = "R1";
        end
        drv_v = 1'b0; drv_cfg = '0;
        for (int p = 0; p < 4; p++) begin drv_d[p] = 0; drv_e[p] = 0; end
        rst_n = 1'b1;
        apply_and_model();

        // R2: all exponent codes, both signs, every channel on port 0
        phase_tag = "R2";
        drv_v = 1'b1; drv_cfg = '0;
        for (int e = 0; e < 8; e++) begin
            foreach (drv_d[p]) begin drv_d[p] = 1000 * p + 7; drv_e[p] = 0; end
            drv_d[0] = -12345; drv_e[0] = e; step();
            drv_d[0] = 23457;  step();
            drv_d[0] = -32768; step();
            drv_d[0] = -1;     step();
        end
        phase_tag = "";

        // R5: real routing rotations
        for (int r = 0; r < 4; r++) begin
            drv_cfg = '0;
            for (int k = 0; k < NCH; k++) drv_cfg |= chf(k, (k + r) % 4, 1'b0);
            rand_data(); step();
            rand_data(); step();
        end

        // R6 / R7 / R8 with pair 0/1 only
        drv_cfg = chf(0, 0, 1) | chf(1, 2, 1) | chf(2, 1, 1) | chf(3, 5, 0)
                | chf(4, 3, 1) | chf(5, 6, 1);
        drv_cfg[24] = 1'b1;
        repeat (3) begin rand_data(); step(); end

        // R10: pair 2/3 only, pair 0/1 left real
        phase_tag = "R10";
        drv_cfg = chf(0, 0, 1) | chf(1, 2, 1) | chf(2, 3, 1) | chf(3, 7, 1)
                | chf(4, 1, 0) | chf(5, 0, 0);
        drv_cfg[25] = 1'b1;
        repeat (3) begin rand_data(); step(); end
        phase_tag = "";

        // R4: idle cycles with changing inputs
        drv_v = 1'b0;
        repeat (4) begin rand_data(); drv_cfg = 26'($urandom); step(); end

        // Random traffic
        repeat (400) begin
            rand_data();
            drv_v   = ($urandom_range(0, 3) != 0);
            drv_cfg = 26'($urandom);
            step();
        end
        @(negedge clk);
        compare_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule